// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block holds the interrupt-status, controller-status and two system-configuration registers of a NAND-style flash controller. It produces the interrupt line and the ready line that the host sees. The data path and the array sequencer report to it through single-cycle pulses. A completion pulse marks a reset, erase, program or load operation as done. A failure pulse marks an erase, program or load operation as failed.

Software reaches the registers through a simple strobe port: a read strobe with an address returns a value in the same cycle, and a write strobe stores data at the next clock edge. Writing the interrupt register ANDs the written mask into the stored bits. Once the master flag is clear, the block also wipes every error flag. The block also gates the command register. A command is taken only while the master flag is clear. A known code is forwarded to the sequencer as a one-cycle strobe. An unknown code raises a command error at once.

Top module: `flash_irq_ctrl`

## Requirements
- R1: On the asynchronous reset the registers read as follows: configuration-1 0x40C0, configuration-2 0x0000, controller status 0x0000, interrupt status 0x8080. Both irq_o and rdy_o are 1.
- R2: A one-cycle warm_rst_i takes effect at the next clock edge. Afterwards configuration-1 reads 0x40C0 and configuration-2 reads 0x0000. Interrupt status becomes 0x8010. Controller status and the stored command both become 0.
- R3: A pulse on op_done_i[i] sets interrupt-status bit 15 and bit 4+i at the next edge. The indices are i=0 reset, 1 erase, 2 program and 3 load.
- R4: A pulse on op_fail_i[i] sets controller-status bit 10 (command error) and bit 11+i at the next edge. The indices are i=0 erase, 1 program and 2 load.
- R5: A write to the interrupt register (address 3) ANDs the write data into interrupt status. Completion pulses in the same cycle set their bits on top of the result.
- R6: If an interrupt-register write leaves bit 15 clear, controller-status bits 10 to 13 are all cleared. If bit 15 stays set, they are kept.
- R7: irq_o equals interrupt-status bit 15 when configuration-1 bit 6 is 1, and its inverse when that bit is 0. It follows a change with no clock delay.
- R8: rdy_o equals configuration-1 bit 7.
- R9: Reading configuration-1 (address 0) returns the stored value with bits 4:0 forced to 0. Configuration-2 (address 1) reads back all 16 written bits.
- R10: A write to the command register (address 4) while interrupt-status bit 15 is set is ignored. No strobe is issued and the stored code is unchanged.
- R11: An accepted write of a known code raises cmd_go_o for exactly one cycle after the write edge, with cmd_code_o showing the code. The known codes are 00, 13, 80, 1A, 1B, 23, 27, 2A, 2C, 30, 65, 71, 94, 95, B0, F0 and F3 (hex). An accepted unknown code sets interrupt-status bit 15 and controller-status bit 10, and issues no strobe.
- R12: Controller status (address 2) is read-only, so writes to it are ignored. Addresses 5 to 7 read 0. Reads return 0 while reg_rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset pulse |
| reg_addr_i | input | 3 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| op_done_i | input | 4 | Completion pulses: reset, erase, program, load |
| op_fail_i | input | 3 | Failure pulses: erase, program, load |
| cmd_go_o | output | 1 | One-cycle strobe for an accepted known command |
| cmd_code_o | output | 8 | Stored command code |
| irq_o | output | 1 | Interrupt output with programmable polarity |
| rdy_o | output | 1 | Ready output |

## Verification
The bench builds the block at its default 3-bit address and 8-bit command width. At that width the whole command space of 256 codes can be swept. Every code is issued with the master flag clear, so the known/unknown split and the strobe timing are checked code by code. Each bit of the interrupt mask is cleared in turn, and every polarity/ready combination of the configuration register is tried against both master-flag states.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    SEL_CFG1 = 3'd0,
    SEL_CFG2 = 3'd1,
    SEL_STAT = 3'd2,
    SEL_INT  = 3'd3,
    SEL_CMD  = 3'd4
  } reg_sel_e;

  localparam int MASTER_BIT = 15;
  localparam int DONE_LSB   = 4;
  localparam int NUM_DONE   = 4;
  localparam int ERR_CMD    = 10;
  localparam int ERR_LSB    = 11;
  localparam int NUM_FAIL   = 3;
  localparam int POL_BIT    = 6;
  localparam int RDY_BIT    = 7;
  localparam int CFG1_LOW   = 5;

  localparam logic [DW-1:0] CFG1_RST     = 16'h40C0;
  localparam logic [DW-1:0] CFG2_RST     = 16'h0000;
  localparam logic [DW-1:0] INT_COLD_RST = 16'h8080;
  localparam logic [DW-1:0] INT_WARM_RST = 16'h8010;

  function automatic logic cmd_known(input logic [7:0] c);
    case (c)
      8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A, 8'h2C,
      8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0, 8'hF0, 8'hF3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fic_int_stat.sv
module fic_int_stat
  import fic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                warm_rst_i,
  input  logic                int_wr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NUM_DONE-1:0] done_i,
  input  logic [NUM_FAIL-1:0] fail_i,
  input  logic                unk_i,
  output logic [DW-1:0]       int_q_o,
  output logic [DW-1:0]       err_q_o
);
  logic [DW-1:0] int_q, err_q, int_set, err_set, int_masked, int_nx, err_nx;
  logic          wipe;

  always_comb begin
    int_set = '0;
    err_set = '0;
    for (int i = 0; i < NUM_DONE; i++) int_set[DONE_LSB+i] = done_i[i];
    for (int i = 0; i < NUM_FAIL; i++) err_set[ERR_LSB+i]  = fail_i[i];
    int_set[MASTER_BIT] = (|done_i) | unk_i;
    err_set[ERR_CMD]    = (|fail_i) | unk_i;
  end

  always_comb begin
    int_masked = int_wr_i ? (int_q & wdata_i) : int_q;
    wipe       = int_wr_i && !int_masked[MASTER_BIT];
    int_nx     = int_masked | int_set;
    err_nx     = (wipe ? '0 : err_q) | err_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= INT_COLD_RST;
      err_q <= '0;
    end else if (warm_rst_i) begin
      int_q <= INT_WARM_RST;
      err_q <= '0;
    end else begin
      int_q <= int_nx;
      err_q <= err_nx;
    end
  end

  assign int_q_o = int_q;
  assign err_q_o = err_q;

  // R3
  done_sets_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i && !warm_rst_i) |=> int_q_o[MASTER_BIT]);

  // R6
  err_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_wr_i && !wdata_i[MASTER_BIT] && done_i == '0 && fail_i == '0 && !unk_i && !warm_rst_i)
    |=> err_q_o == '0);

  // R5
  master_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_q_o[MASTER_BIT]) |-> $past(|done_i || unk_i || warm_rst_i));
endmodule

// File: rtl/fic_cfg_regs.sv
module fic_cfg_regs
  import fic_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_i,
  input  logic          cfg1_wr_i,
  input  logic          cfg2_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          master_i,
  output logic [DW-1:0] cfg1_o,
  output logic [DW-1:0] cfg2_o,
  output logic          irq_o,
  output logic          rdy_o
);
  logic [DW-1:0] cfg1_q, cfg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= CFG2_RST;
    end else if (warm_rst_i) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= CFG2_RST;
    end else begin
      if (cfg1_wr_i) cfg1_q <= wdata_i;
      if (cfg2_wr_i) cfg2_q <= wdata_i;
    end
  end

  // active-high when polarity bit set, active-low otherwise
  assign irq_o  = cfg1_q[POL_BIT] ? master_i : ~master_i;
  assign rdy_o  = cfg1_q[RDY_BIT];
  assign cfg1_o = {cfg1_q[DW-1:CFG1_LOW], {CFG1_LOW{1'b0}}};
  assign cfg2_o = cfg2_q;

  // R8
  rdy_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg1_wr_i && !warm_rst_i) |=> $stable(rdy_o));

  // R7
  irq_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg1_wr_i && !warm_rst_i && $stable(master_i)) |=> $stable(irq_o) || !$stable(master_i));
endmodule

// File: rtl/fic_cmd_gate.sv
module fic_cmd_gate
  import fic_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_i,
  input  logic          cmd_wr_i,
  input  logic [CW-1:0] code_i,
  input  logic          busy_i,
  output logic          go_o,
  output logic [CW-1:0] code_o,
  output logic          unk_o
);
  logic          accept, known, go_q;
  logic [CW-1:0] code_q;

  assign accept = cmd_wr_i && !busy_i;
  assign known  = cmd_known(8'(code_i));
  assign unk_o  = accept && !known && !warm_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      code_q <= '0;
    end else if (warm_rst_i) begin
      go_q   <= 1'b0;
      code_q <= '0;
    end else begin
      go_q <= accept && known;
      if (accept) code_q <= code_i;
    end
  end

  assign go_o   = go_q;
  assign code_o = code_q;

  // R10
  go_needs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(cmd_wr_i && !busy_i));

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && busy_i && !warm_rst_i) |=> ($stable(code_o) && !go_o));

  // R11
  go_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !cmd_wr_i) |=> !go_o);
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import fic_pkg::*;
#(
  parameter int AW = 3,
  parameter int CW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                warm_rst_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  input  logic [NUM_DONE-1:0] op_done_i,
  input  logic [NUM_FAIL-1:0] op_fail_i,
  output logic                cmd_go_o,
  output logic [CW-1:0]       cmd_code_o,
  output logic                irq_o,
  output logic                rdy_o
);
  logic [DW-1:0] int_q, err_q, cfg1, cfg2;
  logic          wr_cfg1, wr_cfg2, wr_int, wr_cmd, unk;

  assign wr_cfg1 = reg_wr_i && (reg_addr_i == AW'(SEL_CFG1));
  assign wr_cfg2 = reg_wr_i && (reg_addr_i == AW'(SEL_CFG2));
  assign wr_int  = reg_wr_i && (reg_addr_i == AW'(SEL_INT));
  assign wr_cmd  = reg_wr_i && (reg_addr_i == AW'(SEL_CMD));

  fic_int_stat u_int (
    .clk_i, .rst_ni, .warm_rst_i,
    .int_wr_i (wr_int),
    .wdata_i  (reg_wdata_i),
    .done_i   (op_done_i),
    .fail_i   (op_fail_i),
    .unk_i    (unk),
    .int_q_o  (int_q),
    .err_q_o  (err_q)
  );

  fic_cfg_regs u_cfg (
    .clk_i, .rst_ni, .warm_rst_i,
    .cfg1_wr_i (wr_cfg1),
    .cfg2_wr_i (wr_cfg2),
    .wdata_i   (reg_wdata_i),
    .master_i  (int_q[MASTER_BIT]),
    .cfg1_o    (cfg1),
    .cfg2_o    (cfg2),
    .irq_o,
    .rdy_o
  );

  fic_cmd_gate #(.CW(CW)) u_cmd (
    .clk_i, .rst_ni, .warm_rst_i,
    .cmd_wr_i (wr_cmd),
    .code_i   (reg_wdata_i[CW-1:0]),
    .busy_i   (int_q[MASTER_BIT]),
    .go_o     (cmd_go_o),
    .code_o   (cmd_code_o),
    .unk_o    (unk)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      case (reg_addr_i)
        AW'(SEL_CFG1): reg_rdata_o = cfg1;
        AW'(SEL_CFG2): reg_rdata_o = cfg2;
        AW'(SEL_STAT): reg_rdata_o = err_q;
        AW'(SEL_INT):  reg_rdata_o = int_q;
        AW'(SEL_CMD):  reg_rdata_o = DW'(cmd_code_o);
        default:       reg_rdata_o = '0;
      endcase
    end
  end

  // R4
  fail_sets_cmd_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|op_fail_i && !warm_rst_i) |=> err_q[ERR_CMD]);
endmodule

// File: tb/tb_flash_irq_ctrl.sv
module tb_flash_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [3:0]  op_done_i = '0;
  logic [2:0]  op_fail_i = '0;
  logic        cmd_go_o;
  logic [7:0]  cmd_code_o;
  logic        irq_o, rdy_o;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  flash_irq_ctrl dut (
    .clk_i(clk), .rst_ni, .warm_rst_i, .reg_addr_i, .reg_wr_i, .reg_rd_i,
    .reg_wdata_i, .reg_rdata_o, .op_done_i, .op_fail_i, .cmd_go_o,
    .cmd_code_o, .irq_o, .rdy_o
  );

  function automatic bit known(input logic [7:0] c);
    case (c)
      8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A, 8'h2C,
      8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0, 8'hF0, 8'hF3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    tick();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1;
    d = reg_rdata_o;
    reg_rd_i = 1'b0;
  endtask

  task automatic pulse_done(input logic [3:0] d);
    op_done_i = d; tick(); op_done_i = '0;
  endtask

  task automatic pulse_fail(input logic [2:0] f);
    op_fail_i = f; tick(); op_fail_i = '0;
  endtask

  task automatic cold_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v, exp_err;
    cold_reset();

    // R1 reset values
    rd(3'd0, v); chk("R1 cfg1", v, 16'h40C0);
    rd(3'd1, v); chk("R1 cfg2", v, 16'h0000);
    rd(3'd2, v); chk("R1 stat", v, 16'h0000);
    rd(3'd3, v); chk("R1 int", v, 16'h8080);
    chk("R1 irq", {15'd0, irq_o}, 16'd1);
    chk("R1 rdy", {15'd0, rdy_o}, 16'd1);

    // R12 unmapped and read strobe gating
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk("R12 unmapped", v, 16'h0000);
    end
    reg_addr_i = 3'd3; #1; chk("R12 no strobe", reg_rdata_o, 16'h0000);

    // R9 R8 R7 configuration sweep, master set then clear
    for (int m = 0; m < 2; m++) begin
      if (m == 1) wr(3'd3, 16'h0000);
      for (int b = 0; b < 18; b++) begin
        logic [15:0] cv;
        cv = (b < 16) ? 16'(1 << b) : ((b == 16) ? 16'hFFFF : 16'h0000);
        wr(3'd0, cv);
        rd(3'd0, v); chk("R9 cfg1 read", v, cv & 16'hFFE0);
        chk("R8 rdy", {15'd0, rdy_o}, {15'd0, cv[7]});
        chk("R7 irq", {15'd0, irq_o}, {15'd0, cv[6] ? (m == 0) : (m != 0)});
      end
    end
    for (int b = 0; b < 16; b++) begin
      wr(3'd1, 16'(1 << b) ^ 16'h5A5A);
      rd(3'd1, v); chk("R9 cfg2 read", v, 16'(1 << b) ^ 16'h5A5A);
    end
    wr(3'd0, 16'h40C0);

    // R3 each completion pulse
    for (int i = 0; i < 4; i++) begin
      wr(3'd3, 16'h0000);
      pulse_done(4'(1 << i));
      rd(3'd3, v); chk("R3 done bit", v, 16'h8000 | 16'(1 << (4 + i)));
    end

    // R5 AND mask per bit
    for (int k = 0; k < 16; k++) begin
      pulse_done(4'hF);
      wr(3'd3, ~16'(1 << k));
      rd(3'd3, v); chk("R5 and mask", v, 16'h80F0 & ~16'(1 << k));
    end
    // R5 same-cycle set wins
    op_done_i = 4'b0010; wr(3'd3, 16'h0000); op_done_i = '0;
    rd(3'd3, v); chk("R5 set wins", v, 16'h8020);

    // R4 failures accumulate
    wr(3'd3, 16'h0000);
    exp_err = 16'h0000;
    for (int i = 0; i < 3; i++) begin
      pulse_fail(3'(1 << i));
      exp_err = exp_err | 16'h0400 | 16'(1 << (11 + i));
      rd(3'd2, v); chk("R4 fail bits", v, exp_err);
    end
    // R6 master stays set -> errors kept; then cleared -> wiped
    pulse_done(4'b0100);
    wr(3'd3, 16'hFFFF);
    rd(3'd2, v); chk("R6 kept", v, 16'h3C00);
    wr(3'd3, 16'h7FFF);
    rd(3'd2, v); chk("R6 wiped", v, 16'h0000);
    rd(3'd3, v); chk("R5 mask master", v, 16'h0040);

    // R12 status read-only
    pulse_fail(3'b001);
    wr(3'd2, 16'h0000);
    rd(3'd2, v); chk("R12 stat ro", v, 16'h0C00);
    wr(3'd3, 16'h0000);

    // R11 sweep all command codes
    for (int c = 0; c < 256; c++) begin
      wr(3'd3, 16'h0000);
      wr(3'd4, 16'(c));
      chk("R11 go", {15'd0, cmd_go_o}, {15'd0, known(8'(c))});
      chk("R11 code", {8'd0, cmd_code_o}, 16'(c));
      rd(3'd3, v); chk("R11 int", v, known(8'(c)) ? 16'h0000 : 16'h8000);
      rd(3'd2, v); chk("R11 stat", v, known(8'(c)) ? 16'h0000 : 16'h0400);
      tick();
      chk("R11 go one cycle", {15'd0, cmd_go_o}, 16'd0);
    end

    // R10 command ignored while master set
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0094);
    tick();
    pulse_done(4'b0010);
    for (int c = 0; c < 4; c++) begin
      logic [7:0] cc;
      cc = (c == 0) ? 8'h80 : ((c == 1) ? 8'h00 : ((c == 2) ? 8'h55 : 8'hF3));
      wr(3'd4, {8'd0, cc});
      chk("R10 no go", {15'd0, cmd_go_o}, 16'd0);
      rd(3'd4, v); chk("R10 code kept", v, 16'h0094);
      rd(3'd2, v); chk("R10 no err", v, 16'h0000);
    end

    // R2 warm reset
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h1234);
    pulse_fail(3'b111);
    warm_rst_i = 1'b1; tick(); warm_rst_i = 1'b0;
    rd(3'd0, v); chk("R2 cfg1", v, 16'h40C0);
    rd(3'd1, v); chk("R2 cfg2", v, 16'h0000);
    rd(3'd3, v); chk("R2 int", v, 16'h8010);
    rd(3'd2, v); chk("R2 stat", v, 16'h0000);
    rd(3'd4, v); chk("R2 cmd", v, 16'h0000);

    // R1 cold reset again
    cold_reset();
    rd(3'd3, v); chk("R1 int again", v, 16'h8080);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule